// File: doc/BRIEF.md
# Programmable Interval Timer with Periodic, Single-Shot and Duty-Cycle Modes

This block counts clock ticks against a programmed interval length and drives one output, `q`. One counter core serves three behaviours, chosen by a two-bit mode input. In periodic mode, `q` gives a one-cycle pulse at the end of every interval. In single-shot mode, `q` gives one pulse and the timer then waits until it is re-armed. In duty-cycle mode, `q` is high for the first `high_time` ticks of each interval and low for the rest.

Time is measured in whole clock ticks. At a 25 MHz clock a tick lasts 40 ns, so a 120 ns interval is programmed as 3. The counter returns to zero when it reaches the last tick of the interval, in the way a modulo counter does. The interval length, the high time and the mode are captured into shadow registers only when the timer starts and when the counter wraps. A host can therefore rewrite them at any time without producing a truncated or stretched interval.

Top module: `tick_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the count and holds `q` low. After reset is released, the timer starts on the first edge at which `en` is high.
- R2: Periodic mode (`mode`=0). The timer starts on the first edge with `en` high, and the cycle after that edge is tick 0. `q` pulses on tick L-1 of every interval, where L = `period`, and a `period` of 0 counts as 1. This gives exactly one pulse per L cycles.
- R3: Single-shot mode (`mode`=1). `q` pulses once, on tick L-1, and the timer then stays idle with `q` low while `en` stays high. Firing again needs `en` to go low for at least one edge and then high again.
- R4: Duty-cycle mode (`mode`=2). Within each interval of L ticks, `q` is high on ticks 0 through `high_time`-1 and low on the remaining ticks.
- R5: In duty-cycle mode, `high_time` >= L keeps `q` high for as long as the timer runs, and `high_time` = 0 keeps `q` low.
- R6: A change to `period`, `high_time` or `mode` while the timer runs takes effect only at the next wrap of the counter. The interval in progress finishes with the old values.
- R7: `en` low at an edge stops the timer and clears its count, so `q` is low in the following cycle.
- R8: `mode`=3 is the off setting. The timer does not start in this mode, and a running timer that finds `mode`=3 at its wrap stops, so `q` stays low.
- R9: In periodic and single-shot modes, each pulse on `q` lasts exactly one cycle, except when L = 1. With L = 1 in periodic mode, `q` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; a low level stops the timer and re-arms single-shot mode |
| mode | input | 2 | 0 periodic, 1 single-shot, 2 duty-cycle, 3 off |
| period | input | CW (16) | Interval length in ticks; 0 counts as 1 |
| high_time | input | CW (16) | Ticks that `q` stays high per interval in duty-cycle mode |
| q | output | 1 | Timer output |

## Verification
Every fault inside this block shows up as a pulse on `q` that is early, late, missing or extra.

- A wrong limit or a wrong count value moves the next pulse or duty-cycle edge. This is visible within one interval.
- A shadow register that reloads at the wrong moment changes the interval length only after the next wrap. The checks therefore watch a change made in the middle of an interval through two whole intervals.
- A single-shot flag that is never cleared, or never set, shows only after a re-arm or after a second interval has elapsed. For that reason the single-shot checks run several intervals past the pulse.

A reference model compares `q` on every clock, so the first wrong cycle is reported.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_PERIODIC = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_PWM      = 2'd2,
    MODE_OFF      = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/tmr_shadow.sv
// Shadow registers for the interval length, high time and mode.
// They reload only when the core asks for it (at start or at a wrap).
module tmr_shadow #(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [CW-1:0]       period_in,
  input  logic [CW-1:0]       high_in,
  input  tmr_pkg::tmr_mode_e  mode_in,
  output logic [CW-1:0]       lim_q,
  output logic [CW-1:0]       hi_q,
  output tmr_pkg::tmr_mode_e  mode_q
);
  import tmr_pkg::*;

  // An interval length of zero is treated as one tick.
  function automatic logic [CW-1:0] eff_limit(input logic [CW-1:0] p);
    return (p == '0) ? CW'(1) : p;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q  <= CW'(1);
      hi_q   <= '0;
      mode_q <= MODE_OFF;
    end else if (load) begin
      lim_q  <= eff_limit(period_in);
      hi_q   <= high_in;
      mode_q <= mode_in;
    end
  end

endmodule

// File: rtl/tmr_core.sv
// Tick counter with run and single-shot control.
module tmr_core #(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  tmr_pkg::tmr_mode_e  mode_in,
  input  tmr_pkg::tmr_mode_e  mode_r,
  input  logic [CW-1:0]       lim,
  output logic [CW-1:0]       cnt,
  output logic                running,
  output logic                done,
  output logic                ev_start,
  output logic                ev_wrap,
  output logic                ev_load
);
  import tmr_pkg::*;

  // True on the final tick of an interval of length l.
  function automatic logic last_tick(input logic [CW-1:0] c,
                                     input logic [CW-1:0] l);
    return c == (l - CW'(1));
  endfunction

  logic [CW-1:0] cnt_nx;
  logic          run_nx;
  logic          done_nx;

  assign ev_start = !running && en && !done && (mode_in != MODE_OFF);
  assign ev_wrap  = running && en && last_tick(cnt, lim);
  assign ev_load  = ev_start || ev_wrap;

  always_comb begin
    cnt_nx  = cnt;
    run_nx  = running;
    done_nx = done;
    if (!en) begin
      cnt_nx  = '0;
      run_nx  = 1'b0;
      done_nx = 1'b0;
    end else if (ev_start) begin
      cnt_nx = '0;
      run_nx = 1'b1;
    end else if (ev_wrap) begin
      cnt_nx = '0;
      if (mode_r == MODE_ONESHOT) begin
        run_nx  = 1'b0;
        done_nx = 1'b1;
      end else if (mode_in == MODE_OFF) begin
        run_nx = 1'b0;
      end
    end else if (running) begin
      cnt_nx = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      running <= run_nx;
      done    <= done_nx;
    end
  end

endmodule

// File: rtl/tmr_outdec.sv
// Output decode: a single pulse on the last tick, or a duty-cycle level.
module tmr_outdec #(
  parameter int CW = 16
) (
  input  logic                running,
  input  tmr_pkg::tmr_mode_e  mode_r,
  input  logic [CW-1:0]       cnt,
  input  logic [CW-1:0]       lim,
  input  logic [CW-1:0]       hi,
  output logic                q
);
  import tmr_pkg::*;

  function automatic logic pwm_level(input logic [CW-1:0] c,
                                     input logic [CW-1:0] h);
    return c < h;
  endfunction

  function automatic logic end_pulse(input logic [CW-1:0] c,
                                     input logic [CW-1:0] l);
    return c == (l - CW'(1));
  endfunction

  always_comb begin
    q = 1'b0;
    if (running) begin
      unique case (mode_r)
        MODE_PERIODIC, MODE_ONESHOT: q = end_pulse(cnt, lim);
        MODE_PWM:                    q = pwm_level(cnt, hi);
        default:                     q = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] high_time,
  output logic          q
);
  import tmr_pkg::*;

  tmr_mode_e     mode_in;
  tmr_mode_e     mode_r;
  logic [CW-1:0] lim;
  logic [CW-1:0] hi;
  logic [CW-1:0] cnt;
  logic          running;
  logic          done;
  logic          ev_start;
  logic          ev_wrap;
  logic          ev_load;

  assign mode_in = tmr_mode_e'(mode);

  tmr_shadow #(.CW(CW)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .load      (ev_load),
    .period_in (period),
    .high_in   (high_time),
    .mode_in   (mode_in),
    .lim_q     (lim),
    .hi_q      (hi),
    .mode_q    (mode_r)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode_in  (mode_in),
    .mode_r   (mode_r),
    .lim      (lim),
    .cnt      (cnt),
    .running  (running),
    .done     (done),
    .ev_start (ev_start),
    .ev_wrap  (ev_wrap),
    .ev_load  (ev_load)
  );

  tmr_outdec #(.CW(CW)) u_out (
    .running (running),
    .mode_r  (mode_r),
    .cnt     (cnt),
    .lim     (lim),
    .hi      (hi),
    .q       (q)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [1:0]    mode,
  input logic          q,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim,
  input logic [CW-1:0] hi,
  input logic [1:0]    mode_r,
  input logic          running,
  input logic          done,
  input logic          ev_wrap,
  input logic          ev_load
);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !running && !q));

  // R2
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < lim));

  // R3
  a_r3_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (ev_wrap && mode_r == 2'd1) |=> (!running && done && !q));

  // R3
  a_r3_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (done && en) |=> (done && !q));

  // R5
  a_r5_pwm_full: assert property (@(posedge clk) disable iff (rst)
    (running && mode_r == 2'd2 && hi >= lim) |-> q);

  // R6
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !ev_load |=> ($stable(lim) && $stable(hi) && $stable(mode_r)));

  // R7
  a_r7_disable: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!running && cnt == '0 && !q));

  // R8
  a_r8_off_no_start: assert property (@(posedge clk) disable iff (rst)
    (!running && mode == 2'd3) |=> !running);

  // R9
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (q && mode_r != 2'd2) |=> (!q || lim == CW'(1)));

endmodule

bind tick_timer tick_timer_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .mode    (mode),
  .q       (q),
  .cnt     (cnt),
  .lim     (lim),
  .hi      (hi),
  .mode_r  (mode_r),
  .running (running),
  .done    (done),
  .ev_wrap (ev_wrap),
  .ev_load (ev_load)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] period = 16'd5;
  logic [15:0] high_time = 16'd0;
  logic        q;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst(rst), .en(en), .mode(mode),
    .period(period), .high_time(high_time), .q(q)
  );

  // Behavioural reference model: an active flag, the tick index inside the
  // current interval, the captured settings, and a fired flag.
  int  m_tick = 0;
  int  m_len = 1;
  int  m_hi = 0;
  int  m_kind = 3;
  bit  m_act = 0;
  bit  m_fired = 0;

  function automatic bit model_q();
    if (!m_act) return 0;
    if (m_kind == 2) return m_tick < m_hi;
    return m_tick == m_len - 1;
  endfunction

  always @(posedge clk) begin
    if (rst || !en) begin
      m_act = 0; m_tick = 0; m_fired = 0;
    end else if (!m_act) begin
      if (!m_fired && mode != 2'd3) begin
        m_act = 1; m_tick = 0;
        m_len = (period == 0) ? 1 : int'(period);
        m_hi = int'(high_time); m_kind = int'(mode);
      end
    end else if (m_tick == m_len - 1) begin
      m_tick = 0;
      if (m_kind == 1) begin
        m_act = 0; m_fired = 1;
      end else if (mode == 2'd3) begin
        m_act = 0;
      end else begin
        m_len = (period == 0) ? 1 : int'(period);
        m_hi = int'(high_time); m_kind = int'(mode);
      end
    end else begin
      m_tick++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: wait to the falling edge, compare q with the model.
  task automatic tick();
    @(negedge clk);
    chk({cur_req, " q per cycle"}, int'(q), int'(model_q()));
  endtask

  task automatic run(input int n, output int highs, output int dbl);
    bit prev = 0;
    highs = 0; dbl = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (q) highs++;
      if (q && prev) dbl++;
      prev = q;
    end
  endtask

  task automatic restart(input logic [1:0] md, input int p, input int h);
    en = 0;
    tick(); tick();
    mode = md; period = 16'(p); high_time = 16'(h);
    en = 1;
    tick();
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int h, d;
    // R1: reset holds q low
    cur_req = "R1";
    en = 1; mode = 2'd0; period = 16'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 q low in reset", int'(q), 0);
    end
    @(negedge clk); rst = 0;
    run(4, h, d);
    chk("R1 first run after reset P=2", h, 2);

    // R2: periodic, P=5 over 10 intervals
    cur_req = "R2";
    en = 0; mode = 2'd0; period = 16'd5;
    tick(); tick(); en = 1;
    run(50, h, d);
    chk("R2 periodic pulses P=5", h, 10);
    chk("R9 no double pulse", d, 0);
    // R2: period 0 counts as 1, q high every cycle
    restart(2'd0, 0, 0);
    run(9, h, d);
    chk("R2 period zero pulses", h, 10 - 1);

    // R3: single-shot
    cur_req = "R3";
    en = 0; mode = 2'd1; period = 16'd4;
    tick(); tick(); en = 1;
    run(40, h, d);
    chk("R3 single pulse", h, 1);
    run(10, h, d);
    chk("R3 stays idle with en high", h, 0);
    en = 0; tick(); en = 1;
    run(8, h, d);
    chk("R3 re-arm fires again", h, 1);
    chk("R9 oneshot pulse width", d, 0);

    // R4: duty cycle
    cur_req = "R4";
    en = 0; mode = 2'd2; period = 16'd8; high_time = 16'd3;
    tick(); tick(); en = 1;
    run(64, h, d);
    chk("R4 pwm high ticks 3/8", h, 24);

    // R5: full and zero duty
    cur_req = "R5";
    en = 0; mode = 2'd2; period = 16'd6; high_time = 16'd10;
    tick(); tick(); en = 1;
    run(30, h, d);
    chk("R5 high_time>=period stays high", h, 30);
    en = 0; high_time = 16'd0;
    tick(); tick(); en = 1;
    run(30, h, d);
    chk("R5 high_time zero stays low", h, 0);

    // R6: mid-interval change waits for wrap
    cur_req = "R6";
    en = 0; mode = 2'd0; period = 16'd10;
    tick(); tick(); en = 1;
    run(3, h, d);
    period = 16'd4;
    run(27, h, d);
    chk("R6 new period after wrap", h, 6);
    en = 0; mode = 2'd2; period = 16'd8; high_time = 16'd2;
    tick(); tick(); en = 1;
    run(1, h, d);
    high_time = 16'd6;
    run(7, h, d);
    chk("R6 old high_time finishes interval", h, 1);
    run(8, h, d);
    chk("R6 new high_time next interval", h, 6);

    // R7: enable drop stops the timer
    cur_req = "R7";
    en = 0; mode = 2'd0; period = 16'd3;
    tick(); tick(); en = 1;
    run(2, h, d);
    en = 0;
    run(6, h, d);
    chk("R7 q low after en drop", h, 0);

    // R8: off mode
    cur_req = "R8";
    en = 0; mode = 2'd3; period = 16'd2;
    tick(); tick(); en = 1;
    run(20, h, d);
    chk("R8 off mode no pulses", h, 0);
    en = 0; mode = 2'd0; period = 16'd4;
    tick(); tick(); en = 1;
    run(2, h, d);
    mode = 2'd3;
    run(20, h, d);
    chk("R8 off at wrap stops", h, 1);

    finish_up();
  end

endmodule